// File: doc/BRIEF.md
# Sector-Framed Byte Stream Receiver

This block takes bytes from a disc-drive signal processor and passes them to an on-chip consumer. The drive side presents an 8-bit bus with four qualifier lines: a strobe, a data-valid line, a start-of-sector marker and an error line. The block drives a request line back to throttle the sender. Each of these five lines has its own configurable active level. For the strobe, that setting chooses which edge captures data. All drive-side inputs pass through a two-flop synchroniser into the system clock domain. The block then finds the active strobe edge and captures the byte when valid is active. The sector-start and error markers sampled on that same edge travel with the byte.

Captured bytes go into a small first-word-fall-through FIFO. The consumer reads it with a valid/ready handshake. The request line follows the FIFO's free space with hysteresis, so the sender can stop before storage runs out. If a byte arrives while the FIFO is full, it is discarded and a sticky overflow flag is raised. The flag stays set until the clear input is pulsed.

Top module: `sector_byte_rx`

## Requirements
- R1: During reset, and on the first clock after it, `drv_req` is low, `out_valid` is 0 and `ovf_flag` is 0.
- R2: A byte is captured once for each active strobe edge. The active edge is rising when `cfg_strb_fall`=0 and falling when `cfg_strb_fall`=1. No other strobe activity captures a byte.
- R3: `drv_valid` is active high when `cfg_vld_hi`=1 and active low when it is 0. A strobe edge that occurs while valid is inactive captures nothing and leaves the FIFO unchanged.
- R4: `out_sos` carries the start-of-sector line sampled on the capturing edge. It is active high when `cfg_sos_hi`=1 and active low otherwise, and is reported as 1 when active.
- R5: `out_err` carries the error line sampled on the capturing edge, under the same polarity rule as R4, selected by `cfg_err_hi`.
- R6: Bytes leave in arrival order. `out_valid` is 1 whenever the FIFO holds data. A byte is removed on a clock where `out_valid` and `out_ready` are both 1. Otherwise the head word does not change.
- R7: The internal request goes inactive once the FIFO has 2 or fewer free entries. It goes active once at least 4 are free. With exactly 3 free, it keeps its previous state.
- R8: `drv_req` shows the internal request as a high level when `cfg_req_hi`=1 and as a low level when `cfg_req_hi`=0.
- R9: A byte captured while the FIFO is full is dropped, and the stored bytes are kept. The drop sets `ovf_flag`, which stays set until a clock with `ovf_clr`=1 clears it. The clear takes precedence over a drop in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| drv_data | input | 8 | Byte bus from the drive processor |
| drv_strobe | input | 1 | Capture strobe, edge chosen by `cfg_strb_fall` |
| drv_valid | input | 1 | Data-valid qualifier |
| drv_sos | input | 1 | Start-of-sector marker |
| drv_err | input | 1 | Error marker |
| drv_req | output | 1 | Data request toward the sender |
| cfg_strb_fall | input | 1 | 1: falling strobe edge captures |
| cfg_vld_hi | input | 1 | 1: valid is active high |
| cfg_sos_hi | input | 1 | 1: start-of-sector is active high |
| cfg_err_hi | input | 1 | 1: error is active high |
| cfg_req_hi | input | 1 | 1: request is driven active high |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow indication |
| out_valid | output | 1 | Head word available |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | 8 | Head byte |
| out_sos | output | 1 | Head byte's start-of-sector tag |
| out_err | output | 1 | Head byte's error tag |

## Verification
Capture is tried under random combinations of all five polarities, using random bytes and tags. Some strobe edges in this stimulus come with valid inactive. This shows whether each polarity setting is applied to its own line, and whether the tags stay attached to the correct byte.

A directed fill, one byte at a time, followed by single reads, walks the free-space count through 3 in both directions. This separates true hysteresis from a single threshold. A ninth byte sent into a full FIFO shows whether the drop leaves the stored bytes intact, and whether the overflow flag is sticky and can be cleared.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef struct packed {
        logic       sos;
        logic       err;
        logic [7:0] data;
    } rx_word_t;

    localparam int unsigned WORD_W = $bits(rx_word_t);

    // Map a raw line level to "active" under a per-line polarity setting.
    function automatic logic to_active(input logic raw, input logic act_high);
        return act_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sbr_capture.sv
module sbr_capture
    import sbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] s_data,
    input  logic       s_strobe,
    input  logic       s_valid,
    input  logic       s_sos,
    input  logic       s_err,
    input  logic       cfg_strb_fall,
    input  logic       cfg_vld_hi,
    input  logic       cfg_sos_hi,
    input  logic       cfg_err_hi,
    output logic       push,
    output rx_word_t   word
);
    logic       stb_norm;
    logic       stb_prev;
    logic [1:0] arm_cnt;
    logic       armed;

    // Strobe normalised so the active edge is always a rising one.
    assign stb_norm = s_strobe ^ cfg_strb_fall;
    // Edges are ignored until the synchroniser and history flop hold real samples.
    assign armed    = (arm_cnt == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev <= 1'b0;
            arm_cnt  <= '0;
        end else begin
            stb_prev <= stb_norm;
            if (!armed) arm_cnt <= arm_cnt + 2'd1;
        end
    end

    always_comb begin
        push      = armed && stb_norm && !stb_prev && to_active(s_valid, cfg_vld_hi);
        word.data = s_data;
        word.sos  = to_active(s_sos, cfg_sos_hi);
        word.err  = to_active(s_err, cfg_err_hi);
    end
endmodule

// File: rtl/sbr_fifo.sv
module sbr_fifo
    import sbr_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rx_word_t      wr_word,
    input  logic          pop_req,
    output rx_word_t      head,
    output logic          nonempty,
    output logic          dropped,
    output logic [CW-1:0] free_cnt
);
    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            full, do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (count == CW'(DEPTH));
    assign nonempty = (count != '0);
    assign do_wr    = push && !full;
    assign do_rd    = pop_req && nonempty;
    assign dropped  = push && full;
    assign head     = mem[rd_ptr];
    assign free_cnt = CW'(DEPTH) - count;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end
endmodule

// File: rtl/sbr_flow.sv
module sbr_flow #(
    parameter int unsigned CW       = 4,
    parameter int unsigned OFF_FREE = 2,
    parameter int unsigned ON_FREE  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] free_cnt,
    input  logic          cfg_req_hi,
    output logic          req_on,
    output logic          req_pin
);
    logic req_nxt;

    always_comb begin
        if (free_cnt <= CW'(OFF_FREE))     req_nxt = 1'b0;
        else if (free_cnt >= CW'(ON_FREE)) req_nxt = 1'b1;
        else                               req_nxt = req_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_on  <= 1'b0;
            req_pin <= 1'b0;
        end else begin
            req_on  <= req_nxt;
            req_pin <= cfg_req_hi ? req_on : ~req_on;
        end
    end
endmodule

// File: rtl/sector_byte_rx.sv
module sector_byte_rx
    import sbr_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned OFF_FREE = 2,
    parameter int unsigned ON_FREE  = 4,
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] drv_data,
    input  logic       drv_strobe,
    input  logic       drv_valid,
    input  logic       drv_sos,
    input  logic       drv_err,
    output logic       drv_req,
    input  logic       cfg_strb_fall,
    input  logic       cfg_vld_hi,
    input  logic       cfg_sos_hi,
    input  logic       cfg_err_hi,
    input  logic       cfg_req_hi,
    input  logic       ovf_clr,
    output logic       ovf_flag,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sos,
    output logic       out_err
);
    localparam int unsigned SYNC_W = 12;

    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic              push, dropped, req_on;
    rx_word_t          cap_word, head;
    logic [CW-1:0]     free_cnt;

    assign raw_bus = {drv_err, drv_sos, drv_valid, drv_strobe, drv_data};

    sbr_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (syn_bus)
    );

    sbr_capture u_cap (
        .clk           (clk),
        .rst           (rst),
        .s_data        (syn_bus[7:0]),
        .s_strobe      (syn_bus[8]),
        .s_valid       (syn_bus[9]),
        .s_sos         (syn_bus[10]),
        .s_err         (syn_bus[11]),
        .cfg_strb_fall (cfg_strb_fall),
        .cfg_vld_hi    (cfg_vld_hi),
        .cfg_sos_hi    (cfg_sos_hi),
        .cfg_err_hi    (cfg_err_hi),
        .push          (push),
        .word          (cap_word)
    );

    sbr_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wr_word  (cap_word),
        .pop_req  (out_ready),
        .head     (head),
        .nonempty (out_valid),
        .dropped  (dropped),
        .free_cnt (free_cnt)
    );

    sbr_flow #(.CW(CW), .OFF_FREE(OFF_FREE), .ON_FREE(ON_FREE)) u_flow (
        .clk        (clk),
        .rst        (rst),
        .free_cnt   (free_cnt),
        .cfg_req_hi (cfg_req_hi),
        .req_on     (req_on),
        .req_pin    (drv_req)
    );

    always_ff @(posedge clk) begin
        if (rst)          ovf_flag <= 1'b0;
        else if (ovf_clr) ovf_flag <= 1'b0;
        else if (dropped) ovf_flag <= 1'b1;
    end

    assign out_data = head.data;
    assign out_sos  = head.sos;
    assign out_err  = head.err;
endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
    parameter int unsigned CW       = 4,
    parameter int unsigned OFF_FREE = 2,
    parameter int unsigned ON_FREE  = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          drv_req,
    input logic          cfg_req_hi,
    input logic          ovf_clr,
    input logic          ovf_flag,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_sos,
    input logic          out_err,
    input logic [CW-1:0] free_cnt,
    input logic          req_on
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: outputs quiet on the first clock after a reset clock
    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_r1_reset_quiet: assert (!drv_req && !out_valid && !ovf_flag)
                else $error("R1 outputs not quiet after reset");
        end
    end

    a_r6_head_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sos) && $stable(out_err)));

    a_r7_req_off: assert property (@(posedge clk) disable iff (rst)
        (free_cnt <= CW'(OFF_FREE)) |=> !req_on);

    a_r7_req_on: assert property (@(posedge clk) disable iff (rst)
        (free_cnt >= CW'(ON_FREE)) |=> req_on);

    a_r8_pin_level: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drv_req == ($past(cfg_req_hi) ? $past(req_on) : !$past(req_on))));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        ovf_clr |=> !ovf_flag);
endmodule

bind sector_byte_rx sbr_chk #(.CW(CW), .OFF_FREE(OFF_FREE), .ON_FREE(ON_FREE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .drv_req    (drv_req),
    .cfg_req_hi (cfg_req_hi),
    .ovf_clr    (ovf_clr),
    .ovf_flag   (ovf_flag),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_sos    (out_sos),
    .out_err    (out_err),
    .free_cnt   (free_cnt),
    .req_on     (req_on)
);

// File: tb/sim_sector_byte_rx.sv
module sim_sector_byte_rx;
    import sbr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] drv_data;
    logic       drv_strobe, drv_valid, drv_sos, drv_err, drv_req;
    logic       cfg_strb_fall, cfg_vld_hi, cfg_sos_hi, cfg_err_hi, cfg_req_hi;
    logic       ovf_clr, ovf_flag, out_valid, out_ready, out_sos, out_err;
    logic [7:0] out_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    rx_word_t q[$];
    bit       m_req_on;
    bit       m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_byte_rx #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .drv_data(drv_data), .drv_strobe(drv_strobe),
        .drv_valid(drv_valid), .drv_sos(drv_sos), .drv_err(drv_err), .drv_req(drv_req),
        .cfg_strb_fall(cfg_strb_fall), .cfg_vld_hi(cfg_vld_hi), .cfg_sos_hi(cfg_sos_hi),
        .cfg_err_hi(cfg_err_hi), .cfg_req_hi(cfg_req_hi), .ovf_clr(ovf_clr),
        .ovf_flag(ovf_flag), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sos(out_sos), .out_err(out_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit req_next(input bit cur, input int free);
        if (free <= 2) return 1'b0;
        if (free >= 4) return 1'b1;
        return cur;
    endfunction

    function automatic bit exp_pin();
        return cfg_req_hi ? m_req_on : !m_req_on;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit s, input bit e, input bit v);
        @(negedge clk);
        drv_data  = d;
        drv_sos   = cfg_sos_hi ? s : !s;
        drv_err   = cfg_err_hi ? e : !e;
        drv_valid = cfg_vld_hi ? v : !v;
        wait_n(3);
        drv_strobe = !cfg_strb_fall;
        wait_n(3);
        drv_strobe = cfg_strb_fall;
        wait_n(4);
        drv_valid = cfg_vld_hi ? 1'b0 : 1'b1;
        if (v) begin
            if (q.size() < DEPTH) q.push_back('{sos: s, err: e, data: d});
            else m_ovf = 1'b1;
            m_req_on = req_next(m_req_on, DEPTH - q.size());
        end
    endtask

    task automatic pop_one(input string req);
        rx_word_t h;
        h = q[0];
        check(out_valid == 1'b1, "R6 valid", out_valid, 1);
        check(out_data == h.data, {req, " data"}, out_data, h.data);
        check(out_sos == h.sos, "R4 sos tag", out_sos, h.sos);
        check(out_err == h.err, "R5 err tag", out_err, h.err);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        void'(q.pop_front());
        m_req_on = req_next(m_req_on, DEPTH - q.size());
        wait_n(3);
    endtask

    task automatic drain(input string req);
        while (q.size() != 0) pop_one(req);
        check(out_valid == 1'b0, "R6 empty", out_valid, 0);
        check(drv_req == exp_pin(), "R8 req after drain", drv_req, exp_pin());
    endtask

    // Safe reconfiguration: valid first, then strobe, with quiet time between.
    task automatic reconfig(input bit sf, input bit vh, input bit sh, input bit eh, input bit rh);
        @(negedge clk);
        cfg_vld_hi = vh; drv_valid = !vh;
        cfg_sos_hi = sh; cfg_err_hi = eh; cfg_req_hi = rh;
        wait_n(5);
        cfg_strb_fall = sf; drv_strobe = sf;
        wait_n(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EC7);
        rst = 1'b1;
        drv_data = '0; drv_strobe = 1'b0; drv_valid = 1'b0; drv_sos = 1'b0; drv_err = 1'b0;
        cfg_strb_fall = 1'b0; cfg_vld_hi = 1'b1; cfg_sos_hi = 1'b1; cfg_err_hi = 1'b1; cfg_req_hi = 1'b1;
        ovf_clr = 1'b0; out_ready = 1'b0;
        m_req_on = 1'b1; m_ovf = 1'b0;
        wait_n(4);
        // R1 reset state
        check(drv_req == 1'b0, "R1 req low", drv_req, 0);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(ovf_flag == 1'b0, "R1 ovf", ovf_flag, 0);
        rst = 1'b0;
        wait_n(6);
        check(drv_req == 1'b1, "R8 req active high", drv_req, 1);

        // R3 ignored byte with valid inactive
        send(8'hA5, 1'b1, 1'b1, 1'b0);
        check(out_valid == 1'b0, "R3 ignored byte", out_valid, 0);

        // R7 hysteresis walk
        for (int i = 0; i < 6; i++) begin
            send(8'h10 + 8'(i), (i == 0), (i == 3), 1'b1);
            check(drv_req == exp_pin(), "R7 fill", drv_req, exp_pin());
        end
        check(drv_req == 1'b0, "R7 off at free 2", drv_req, 0);
        pop_one("R2");
        check(drv_req == 1'b0, "R7 hold at free 3", drv_req, 0);
        pop_one("R2");
        check(drv_req == 1'b1, "R7 on at free 4", drv_req, 1);
        drain("R6");

        // R9 overflow
        for (int i = 0; i < DEPTH + 1; i++) send(8'hC0 + 8'(i), 1'b0, (i == 8), 1'b1);
        check(ovf_flag == 1'b1, "R9 ovf set", ovf_flag, 1);
        check(out_data == 8'hC0, "R9 head kept", out_data, 8'hC0);
        wait_n(5);
        check(ovf_flag == 1'b1, "R9 ovf sticky", ovf_flag, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf_flag == 1'b0, "R9 ovf cleared", ovf_flag, 0);
        check(q.size() == DEPTH, "R9 model depth", q.size(), DEPTH);
        drain("R9");

        // Random polarity rounds (R2, R3, R4, R5, R8)
        for (int r = 0; r < 8; r++) begin
            int n;
            reconfig($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 1), $urandom_range(0, 1));
            check(drv_req == exp_pin(), "R8 req polarity", drv_req, exp_pin());
            n = $urandom_range(1, 10);
            for (int k = 0; k < n; k++) begin
                bit v;
                v = ($urandom_range(0, 3) != 0) || (q.size() >= DEPTH);
                if (q.size() >= DEPTH) v = 1'b0;
                send(8'($urandom), $urandom_range(0, 1), $urandom_range(0, 1), v);
            end
            check(drv_req == exp_pin(), "R7 req after burst", drv_req, exp_pin());
            drain("R2");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule